// File: doc/BRIEF.md
# Data Cache Fill Scope Decider

This unit looks at one data reference per cycle and decides how much of the data cache the fill engine may bring in for it. The answer is one of three scopes: nothing, only the referenced line, or every line of the page that holds the reference. The decision is based on several things about the reference: what kind of access it is, whether it was nullified, whether its opcode is limited to a single line, whether its page is cacheable, whether it targets I/O space, and the state of the TLB uncacheable bit. An interruption that hit the reference also counts, because only some interruption numbers forbid the fill.

A reference can also be held at the head of the interruption queue behind an older group-4 interruption. It is marked with a flag and is judged as if it had executed. The interruption number it carries is the one it would have raised itself. The scope, a valid strobe, the page-aligned address and the line-aligned address all come out of registers one cycle after the request. The upstream TLB lookup supplies the descriptor, and a downstream fill engine consumes the result.

Top module: `dcache_fill_scope`

## Requirements
- R1: While reset is asserted and right after it, out_valid is 0 and out_scope is 2'b00.
- R2: out_valid equals req_valid from the previous cycle. out_scope is encoded as 2'b00 none, 2'b01 line, 2'b10 page, and never shows 2'b11.
- R3: A request with req_cacheable=0 gives scope none.
- R4: A load (req_kind 2'b00), store (2'b01) or semaphore (2'b10) that is eligible gives scope page. Eligible means: not nullified, not line-only, cacheable, memory space, no blocking uncacheable bit, and no excluded interruption.
- R5: req_kind 2'b11 is not a data reference and gives scope none.
- R6: When req_intr_valid=1 and req_intr_num is 6, 7, 8, 10, 15, 18, 19, 20, 21, 26, 27 or 28, the scope is none. Any other interruption number leaves the scope as R4/R8 give it.
- R7: A request with req_nullified=1 gives scope none.
- R8: A request with req_line_only=1 that is otherwise eligible gives scope line (2'b01) and never page.
- R9: With req_held=1, a load or store follows the same rules as an executed one, and a semaphore gives scope none.
- R10: req_io=1 gives scope none. req_ubit_impl=1 together with req_ubit=1 gives none for a virtual reference (req_absolute=0). For an absolute reference the uncacheable bit has no effect, and req_ubit has no effect when req_ubit_impl=0.
- R11: With out_valid, out_page_addr is the request address with its low PAGE_BITS (12) bits cleared, and out_line_addr is the request address with its low LINE_BITS (6) bits cleared.
- R12: A cycle without req_valid gives out_scope 2'b00 in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | A reference descriptor is present this cycle |
| req_kind | input | 2 | 00 load, 01 store, 10 semaphore, 11 not a reference |
| req_nullified | input | 1 | The instruction was nullified |
| req_line_only | input | 1 | The opcode may fill only the referenced line |
| req_absolute | input | 1 | 1 absolute reference, 0 virtual reference |
| req_io | input | 1 | The reference targets I/O space |
| req_cacheable | input | 1 | The page is cacheable |
| req_ubit_impl | input | 1 | The TLB implements the uncacheable bit |
| req_ubit | input | 1 | Value of the uncacheable bit |
| req_held | input | 1 | The reference is held behind an older group-4 interruption |
| req_intr_valid | input | 1 | An interruption applies to this reference |
| req_intr_num | input | INTR_W (5) | Interruption number |
| req_addr | input | ADDR_W (32) | Reference address |
| out_valid | output | 1 | Registered strobe for the decision |
| out_scope | output | 2 | Registered fill scope |
| out_page_addr | output | ADDR_W (32) | Page-aligned address |
| out_line_addr | output | ADDR_W (32) | Line-aligned address |

## Verification
The assertions assume that reset is held long enough for one clock edge and that every input is a known value at each rising edge. Under that assumption each registered output can be related to the input of the cycle before. The bench drives every input on the falling edge and keeps all of them defined at all times, including the undecoded kind code 3 and interruption numbers across the whole 5-bit range. Random stimulus is biased toward cacheable memory-space references, so that the page and line scopes appear often next to the blocking cases.

// File: rtl/dfs_pkg.sv
package dfs_pkg;
   typedef enum logic [1:0] {
      SCOPE_NONE = 2'b00,
      SCOPE_LINE = 2'b01,
      SCOPE_PAGE = 2'b10
   } scope_e;

   typedef enum logic [1:0] {
      KIND_LOAD  = 2'b00,
      KIND_STORE = 2'b01,
      KIND_SEMA  = 2'b10,
      KIND_RSVD  = 2'b11
   } kind_e;

   typedef struct packed {
      kind_e kind;
      logic  nullified;
      logic  line_only;
      logic  absolute;
      logic  io;
      logic  cacheable;
      logic  ubit_impl;
      logic  ubit;
      logic  held;
   } ref_desc_s;
endpackage

// File: rtl/dfs_intr_filter.sv
module dfs_intr_filter #(
   parameter int unsigned INTR_W      = 5,
   parameter bit          HONOR_INTR  = 1'b1,
   parameter logic [(1<<INTR_W)-1:0] EXCL_MASK = 32'h1C3C_85C0
) (
   input  logic              intr_valid,
   input  logic [INTR_W-1:0] intr_num,
   output logic              intr_blocks
);
   generate
      if (HONOR_INTR) begin : g_lookup
         // one mask bit per interruption number that forbids the fill
         assign intr_blocks = intr_valid & EXCL_MASK[intr_num];
      end else begin : g_ignore
         logic unused_ok;
         assign unused_ok   = intr_valid ^ (^intr_num);
         assign intr_blocks = 1'b0;
      end
   endgenerate
endmodule

// File: rtl/dfs_classify.sv
module dfs_classify
   import dfs_pkg::*;
(
   input  logic      valid,
   input  ref_desc_s desc,
   input  logic      intr_blocks,
   output scope_e    scope
);
   logic is_ref;
   logic ubit_blocks;
   logic space_blocks;

   always_comb begin
      is_ref = (desc.kind != KIND_RSVD) && !desc.nullified
               && !(desc.held && desc.kind == KIND_SEMA);
      // the uncacheable bit lives in the TLB, so only virtual references see it
      ubit_blocks  = desc.ubit_impl && desc.ubit && !desc.absolute;
      space_blocks = !desc.cacheable || desc.io || ubit_blocks;

      if (!valid || !is_ref || intr_blocks || space_blocks)
         scope = SCOPE_NONE;
      else if (desc.line_only)
         scope = SCOPE_LINE;
      else
         scope = SCOPE_PAGE;
   end
endmodule

// File: rtl/dfs_addr_split.sv
module dfs_addr_split #(
   parameter int unsigned ADDR_W    = 32,
   parameter int unsigned PAGE_BITS = 12,
   parameter int unsigned LINE_BITS = 6
) (
   input  logic [ADDR_W-1:0] addr,
   output logic [ADDR_W-1:0] page_addr,
   output logic [ADDR_W-1:0] line_addr
);
   generate
      for (genvar b = 0; b < ADDR_W; b++) begin : g_bit
         if (b < LINE_BITS) begin : g_low
            assign page_addr[b] = 1'b0;
            assign line_addr[b] = 1'b0;
         end else if (b < PAGE_BITS) begin : g_mid
            assign page_addr[b] = 1'b0;
            assign line_addr[b] = addr[b];
         end else begin : g_high
            assign page_addr[b] = addr[b];
            assign line_addr[b] = addr[b];
         end
      end
   endgenerate

   logic unused_low;
   assign unused_low = ^addr[LINE_BITS-1:0];
endmodule

// File: rtl/dcache_fill_scope.sv
module dcache_fill_scope
   import dfs_pkg::*;
#(
   parameter int unsigned ADDR_W     = 32,
   parameter int unsigned PAGE_BITS  = 12,
   parameter int unsigned LINE_BITS  = 6,
   parameter int unsigned INTR_W     = 5,
   parameter bit          HONOR_INTR = 1'b1,
   parameter logic [(1<<INTR_W)-1:0] EXCL_MASK = 32'h1C3C_85C0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic [1:0]        req_kind,
   input  logic              req_nullified,
   input  logic              req_line_only,
   input  logic              req_absolute,
   input  logic              req_io,
   input  logic              req_cacheable,
   input  logic              req_ubit_impl,
   input  logic              req_ubit,
   input  logic              req_held,
   input  logic              req_intr_valid,
   input  logic [INTR_W-1:0] req_intr_num,
   input  logic [ADDR_W-1:0] req_addr,
   output logic              out_valid,
   output logic [1:0]        out_scope,
   output logic [ADDR_W-1:0] out_page_addr,
   output logic [ADDR_W-1:0] out_line_addr
);
   localparam int unsigned LINES_PER_PAGE = 1 << (PAGE_BITS - LINE_BITS);

   generate
      if (PAGE_BITS <= LINE_BITS || PAGE_BITS >= ADDR_W)
         $error("dcache_fill_scope: need LINE_BITS < PAGE_BITS < ADDR_W");
      if (LINE_BITS == 0)
         $error("dcache_fill_scope: LINE_BITS must be at least 1");
      if (INTR_W < 1 || INTR_W > 6)
         $error("dcache_fill_scope: INTR_W must be 1..6");
      if (LINES_PER_PAGE < 2)
         $error("dcache_fill_scope: a page must hold at least two lines");
   endgenerate

   ref_desc_s desc;
   logic      intr_blocks;
   scope_e    scope_d;
   logic [ADDR_W-1:0] page_d, line_d;

   assign desc = '{kind:      kind_e'(req_kind),
                   nullified: req_nullified,
                   line_only: req_line_only,
                   absolute:  req_absolute,
                   io:        req_io,
                   cacheable: req_cacheable,
                   ubit_impl: req_ubit_impl,
                   ubit:      req_ubit,
                   held:      req_held};

   dfs_intr_filter #(
      .INTR_W(INTR_W), .HONOR_INTR(HONOR_INTR), .EXCL_MASK(EXCL_MASK)
   ) u_intr (
      .intr_valid (req_intr_valid),
      .intr_num   (req_intr_num),
      .intr_blocks(intr_blocks)
   );

   dfs_classify u_class (
      .valid      (req_valid),
      .desc       (desc),
      .intr_blocks(intr_blocks),
      .scope      (scope_d)
   );

   dfs_addr_split #(
      .ADDR_W(ADDR_W), .PAGE_BITS(PAGE_BITS), .LINE_BITS(LINE_BITS)
   ) u_addr (
      .addr     (req_addr),
      .page_addr(page_d),
      .line_addr(line_d)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid     <= 1'b0;
         out_scope     <= SCOPE_NONE;
         out_page_addr <= '0;
         out_line_addr <= '0;
      end else begin
         out_valid     <= req_valid;
         out_scope     <= scope_d;
         out_page_addr <= page_d;
         out_line_addr <= line_d;
      end
   end
endmodule

// File: rtl/dfs_checker.sv
module dfs_checker #(
   parameter int unsigned ADDR_W    = 32,
   parameter int unsigned PAGE_BITS = 12,
   parameter int unsigned LINE_BITS = 6
) (
   input logic              clk,
   input logic              rst_n,
   input logic              req_valid,
   input logic              req_nullified,
   input logic              req_line_only,
   input logic              req_io,
   input logic              req_cacheable,
   input logic              out_valid,
   input logic [1:0]        out_scope,
   input logic [ADDR_W-1:0] out_page_addr,
   input logic [ADDR_W-1:0] out_line_addr
);
   logic seen;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) seen <= 1'b0;
      else        seen <= 1'b1;
   end

   p_valid_follow_r2: assert property (@(posedge clk) disable iff (!rst_n)
      seen |-> (out_valid == $past(req_valid)));

   p_no_code3_r2: assert property (@(posedge clk) disable iff (!rst_n)
      out_scope != 2'b11);

   p_uncached_none_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (seen && $past(req_valid && !req_cacheable)) |-> (out_scope == 2'b00));

   p_nullified_none_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (seen && $past(req_valid && req_nullified)) |-> (out_scope == 2'b00));

   p_line_only_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (seen && $past(req_valid && req_line_only)) |-> (out_scope != 2'b10));

   p_io_none_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (seen && $past(req_valid && req_io)) |-> (out_scope == 2'b00));

   p_page_align_r11: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> (out_page_addr[PAGE_BITS-1:0] == '0));

   p_line_align_r11: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> (out_line_addr[LINE_BITS-1:0] == '0
                     && out_line_addr[ADDR_W-1:PAGE_BITS] == out_page_addr[ADDR_W-1:PAGE_BITS]));

   p_idle_none_r12: assert property (@(posedge clk) disable iff (!rst_n)
      !out_valid |-> (out_scope == 2'b00));
endmodule

bind dcache_fill_scope dfs_checker #(
   .ADDR_W(ADDR_W), .PAGE_BITS(PAGE_BITS), .LINE_BITS(LINE_BITS)
) u_dfs_checker (
   .clk          (clk),
   .rst_n        (rst_n),
   .req_valid    (req_valid),
   .req_nullified(req_nullified),
   .req_line_only(req_line_only),
   .req_io       (req_io),
   .req_cacheable(req_cacheable),
   .out_valid    (out_valid),
   .out_scope    (out_scope),
   .out_page_addr(out_page_addr),
   .out_line_addr(out_line_addr)
);

// File: tb/tb_dcache_fill_scope.sv
module tb_dcache_fill_scope;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic [1:0]  req_kind = 2'b00;
   logic        req_nullified = 1'b0, req_line_only = 1'b0, req_absolute = 1'b0;
   logic        req_io = 1'b0, req_cacheable = 1'b0, req_ubit_impl = 1'b0;
   logic        req_ubit = 1'b0, req_held = 1'b0, req_intr_valid = 1'b0;
   logic [4:0]  req_intr_num = 5'd0;
   logic [31:0] req_addr = 32'd0;
   logic        out_valid;
   logic [1:0]  out_scope;
   logic [31:0] out_page_addr, out_line_addr;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   dcache_fill_scope dut (.*);

   function automatic bit excluded(input logic [4:0] n);
      case (n)
         5'd6, 5'd7, 5'd8, 5'd10, 5'd15, 5'd18, 5'd19, 5'd20,
         5'd21, 5'd26, 5'd27, 5'd28: return 1'b1;
         default: return 1'b0;
      endcase
   endfunction

   // returns the requirement that decides the outcome and the expected scope
   function automatic string decide(output logic [1:0] sc);
      sc = 2'b00;
      if (!req_valid)                                  return "R12";
      if (req_kind == 2'b11)                           return "R5";
      if (req_nullified)                               return "R7";
      if (req_held && req_kind == 2'b10)               return "R9";
      if (!req_cacheable)                              return "R3";
      if (req_io)                                      return "R10";
      if (req_ubit_impl && req_ubit && !req_absolute)  return "R10";
      if (req_intr_valid && excluded(req_intr_num))    return "R6";
      if (req_line_only) begin sc = 2'b01;             return "R8"; end
      sc = 2'b10;
      return req_held ? "R9" : "R4";
   endfunction

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   // inputs already set; wait for the registered result and compare
   task automatic step();
      logic [1:0]  sc;
      string       tag;
      logic        v;
      logic [31:0] a;
      tag = decide(sc);
      v = req_valid;
      a = req_addr;
      @(negedge clk);
      check("R2 valid", {31'd0, out_valid}, {31'd0, v});
      check(tag, {30'd0, out_scope}, {30'd0, sc});
      if (v) begin
         check("R11 page", out_page_addr, a & 32'hFFFF_F000);
         check("R11 line", out_line_addr, a & 32'hFFFF_FFC0);
      end
   endtask

   task automatic base_ref(input logic [1:0] kind);
      req_valid = 1'b1; req_kind = kind; req_nullified = 1'b0;
      req_line_only = 1'b0; req_absolute = 1'b0; req_io = 1'b0;
      req_cacheable = 1'b1; req_ubit_impl = 1'b0; req_ubit = 1'b0;
      req_held = 1'b0; req_intr_valid = 1'b0; req_intr_num = 5'd0;
      req_addr = $urandom;
   endtask

   initial begin
      int unused_seed;
      unused_seed = $urandom(32'h5EED_0042);
      repeat (3) @(negedge clk);
      check("R1 valid", {31'd0, out_valid}, 32'd0);
      check("R1 scope", {30'd0, out_scope}, 32'd0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 after", {30'd0, out_scope}, 32'd0);

      // directed corners
      for (int k = 0; k < 4; k++) begin base_ref(2'(k)); step(); end   // R4, R5
      base_ref(2'b00); req_cacheable = 1'b0; step();                   // R3
      base_ref(2'b01); req_nullified = 1'b1; step();                   // R7
      base_ref(2'b10); req_line_only = 1'b1; step();                   // R8
      base_ref(2'b00); req_io = 1'b1; step();                          // R10
      base_ref(2'b00); req_ubit_impl = 1'b1; req_ubit = 1'b1; step();  // R10 blocks
      base_ref(2'b00); req_ubit_impl = 1'b1; req_ubit = 1'b1; req_absolute = 1'b1; step(); // R10 absolute
      base_ref(2'b00); req_ubit = 1'b1; step();                        // R10 not implemented
      for (int n = 0; n < 32; n++) begin                               // R6 full sweep
         base_ref(2'b01); req_intr_valid = 1'b1; req_intr_num = 5'(n); step();
      end
      base_ref(2'b00); req_held = 1'b1; step();                        // R9 load
      base_ref(2'b10); req_held = 1'b1; step();                        // R9 semaphore
      base_ref(2'b01); req_held = 1'b1; req_intr_valid = 1'b1; req_intr_num = 5'd15; step(); // R9 + R6
      base_ref(2'b00); req_addr = 32'hFFFF_FFFF; step();               // R11 all ones
      req_valid = 1'b0; step();                                        // R12

      // constrained random
      for (int i = 0; i < 3000; i++) begin
         req_valid      = ($urandom % 8) != 0;
         req_kind       = 2'($urandom);
         req_nullified  = ($urandom % 8) == 0;
         req_line_only  = ($urandom % 4) == 0;
         req_absolute   = ($urandom % 2) == 0;
         req_io         = ($urandom % 8) == 0;
         req_cacheable  = ($urandom % 5) != 0;
         req_ubit_impl  = ($urandom % 2) == 0;
         req_ubit       = ($urandom % 3) == 0;
         req_held       = ($urandom % 6) == 0;
         req_intr_valid = ($urandom % 3) == 0;
         req_intr_num   = 5'($urandom);
         req_addr       = $urandom;
         step();
      end

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      #(200000 * 10);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end
endmodule